// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state changes a 32-bit soft processor makes when it enters an exception, a breakpoint or a hardware interrupt. Each cycle the core presents its current program counter and status word together with up to three requests: a synchronous exception with a 5-bit cause code, a breakpoint, and a pending interrupt line. The controller picks at most one of them, classifies it and, one clock later, holds the new status word, the saved copies of status and return address, the updated cause and TLB-control registers and the vector the core must fetch from next.

The classification depends on the cause and on whether an exception is already being handled. A TLB miss outside a handler goes to a dedicated fast vector. The same miss inside a handler is recorded as a double miss and sent to the general vector with the saved state left intact. Nested general exceptions and breakpoints likewise keep the state saved by the outer entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has pc_out equal to the RESET_VEC parameter (default 0x0), and status_out, estatus_out, bstatus_out, ea_out, ba_out, cause_out and tlbmisc_out all zero, with entry_done low.
- R2: An interrupt is taken only when irq_req is high, status_in bit 0 (interrupt enable) is set, and neither exc_valid nor brk_valid is high. An interrupt request that is not taken changes no output.
- R3: Interrupt entry copies status_in to estatus_out, sets status bit 3 (interrupt handling), clears bits 0 and 1 (user mode), leaves bit 2 as in status_in, loads ea_out with pc_in+4 and sets pc_out to EXC_VEC (default 0x4).
- R4: Every entry writes its code into cause_out bits 6:2 and leaves all other cause_out bits unchanged. Interrupts record 2, breakpoints record 31, exceptions record exc_cause.
- R5: Cause 12 (TLB miss) with status_in bit 2 (exception handling) clear saves status_in to estatus_out and pc_in+4 to ea_out, sets bit 2, clears bits 0 and 1, clears tlbmisc_out bit 3 (double miss), sets tlbmisc_out bit 18 (write enable) and sets pc_out to FAST_VEC (default 0x8).
- R6: Cause 12 with status bit 2 already set sets tlbmisc_out bit 3, sets status bit 2, clears bits 0 and 1, sets pc_out to EXC_VEC, and leaves estatus_out and ea_out unchanged.
- R7: Any exception cause other than 12 to 15 (such as supervisor 9 and 10, trap 3, illegal 5, misaligned 6) saves status_in and pc_in+4 only when status bit 2 was clear, always sets bit 2, clears bits 0 and 1, and sets pc_out to EXC_VEC.
- R8: Causes 13, 14 and 15 (TLB permission faults) always save status_in and pc_in+4, set bit 2, clear bits 0 and 1, go to EXC_VEC, and set tlbmisc_out bit 18 only when status_in bit 2 was clear.
- R9: A breakpoint saves status_in to bstatus_out and pc_in+4 to ba_out only when status bit 2 was clear, always sets bit 2, clears bits 0 and 1, and sets pc_out to EXC_VEC; estatus_out and ea_out are untouched.
- R10: When several requests coincide, an exception wins over a breakpoint, which wins over an interrupt; the losers have no effect that cycle.
- R11: entry_done is high for exactly the cycle after an accepted entry; in a cycle with no accepted entry every register output holds its value.
- R12: On any entry, status bits 31:4 of status_out equal those of status_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | Synchronous exception request |
| exc_cause | input | 5 | Cause code of the exception request |
| brk_valid | input | 1 | Breakpoint request |
| irq_req | input | 1 | Pending hardware interrupt |
| pc_in | input | 32 | PC of the instruction at which entry happens |
| status_in | input | 32 | Current status word |
| pc_out | output | 32 | Next PC (vector) |
| status_out | output | 32 | Status word after entry |
| estatus_out | output | 32 | Saved status for exceptions and interrupts |
| bstatus_out | output | 32 | Saved status for breakpoints |
| cause_out | output | 32 | Exception-cause register, code in bits 6:2 |
| tlbmisc_out | output | 32 | TLB control register, bit 3 double miss, bit 18 write enable |
| ea_out | output | 32 | Exception return address |
| ba_out | output | 32 | Breakpoint return address |
| entry_done | output | 1 | One-cycle strobe after an accepted entry |

## Verification
Properties check on every cycle the reset values, that a strobe always coincides with a vector in pc_out and cleared enable and user bits, that the bits outside the cause field never move, that an interrupt with enable clear starts nothing, and that a double miss keeps the saved status and return address. Only the bench's scenarios show the full register contents for each class of entry, the nested-entry preservation for general exceptions and breakpoints, the conditional write-enable flag on permission faults and the arbitration when requests coincide, since those need a model of the whole register set.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the exception entry controller.
// Assumes a status word of at least 4 bits and a 5-bit cause code.
package exc_entry_pkg;

    localparam int CODE_W = 5;

    // Status word bit positions
    localparam int ST_PIE = 0;
    localparam int ST_U   = 1;
    localparam int ST_EH  = 2;
    localparam int ST_IH  = 3;

    // TLB control register bit positions
    localparam int TM_DBL = 3;
    localparam int TM_WR  = 18;

    // Cause field position in the cause register
    localparam int CF_LO = 2;
    localparam int CF_HI = CF_LO + CODE_W - 1;

    // Cause codes
    localparam logic [CODE_W-1:0] C_IRQ   = 5'd2;
    localparam logic [CODE_W-1:0] C_TMISS = 5'd12;
    localparam logic [CODE_W-1:0] C_TX    = 5'd13;
    localparam logic [CODE_W-1:0] C_TW    = 5'd15;
    localparam logic [CODE_W-1:0] C_BRK   = 5'd31;

    // Class of the entry selected this cycle
    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_IRQ  = 3'd1,
        K_FAST = 3'd2,
        K_DBL  = 3'd3,
        K_PERM = 3'd4,
        K_GEN  = 3'd5,
        K_BRK  = 3'd6
    } kind_t;

endpackage

// File: rtl/exc_arbiter.sv
// Selects at most one entry per cycle and classifies it.
// Priority: exception, then breakpoint, then enabled interrupt.
// Assumes requests are sampled in the same cycle as status_in.
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_cause,
    input  logic              brk_valid,
    input  logic              irq_req,
    input  logic              pie,
    input  logic              eh,
    output kind_t             kind,
    output logic [CODE_W-1:0] code
);

    // Classify the winning request by cause and handler state
    always_comb begin
        kind = K_NONE;
        code = '0;
        if (exc_valid) begin
            code = exc_cause;
            if (exc_cause == C_TMISS) begin
                kind = eh ? K_DBL : K_FAST;
            end else if (exc_cause >= C_TX && exc_cause <= C_TW) begin
                kind = K_PERM;
            end else begin
                kind = K_GEN;
            end
        end else if (brk_valid) begin
            kind = K_BRK;
            code = C_BRK;
        end else if (irq_req && pie) begin
            kind = K_IRQ;
            code = C_IRQ;
        end
    end

endmodule

// File: rtl/exc_update.sv
// Computes the next values of all entry-affected registers for a
// classified entry. Purely combinational; the caller qualifies the
// results with kind != K_NONE.
module exc_update
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] EXC_VEC  = 32'h4,
    parameter logic [31:0] FAST_VEC = 32'h8
) (
    input  kind_t             kind,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   status_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   cause_q,
    input  logic [XLEN-1:0]   tlbmisc_q,
    output logic [XLEN-1:0]   status_nx,
    output logic [XLEN-1:0]   ret_addr,
    output logic              save_exc,
    output logic              save_brk,
    output logic [XLEN-1:0]   cause_nx,
    output logic [XLEN-1:0]   tlbmisc_nx,
    output logic [XLEN-1:0]   vec_nx
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic eh_before;
    assign eh_before = status_in[ST_EH];

    // New status word: drop enable and user, mark handler kind
    always_comb begin
        status_nx         = status_in;
        status_nx[ST_PIE] = 1'b0;
        status_nx[ST_U]   = 1'b0;
        if (kind == K_IRQ) begin
            status_nx[ST_IH] = 1'b1;
        end else begin
            status_nx[ST_EH] = 1'b1;
        end
    end

    // Decide which saved-state pair is written
    always_comb begin
        save_exc = (kind == K_IRQ) || (kind == K_FAST) || (kind == K_PERM) ||
                   ((kind == K_GEN) && !eh_before);
        save_brk = (kind == K_BRK) && !eh_before;
    end

    // Return address is the instruction after the faulting one
    assign ret_addr = pc_in + INSN_BYTES;

    // Cause field insertion, other bits kept
    always_comb begin
        cause_nx              = cause_q;
        cause_nx[CF_HI:CF_LO] = code;
    end

    // TLB control flag updates per entry class
    always_comb begin
        tlbmisc_nx = tlbmisc_q;
        case (kind)
            K_FAST: begin
                tlbmisc_nx[TM_DBL] = 1'b0;
                tlbmisc_nx[TM_WR]  = 1'b1;
            end
            K_DBL:  tlbmisc_nx[TM_DBL] = 1'b1;
            K_PERM: if (!eh_before) tlbmisc_nx[TM_WR] = 1'b1;
            default: ;
        endcase
    end

    // Vector selection
    assign vec_nx = (kind == K_FAST) ? FAST_VEC[XLEN-1:0] : EXC_VEC[XLEN-1:0];

endmodule

// File: rtl/exc_save_slot.sv
// One saved-state pair: a status copy and a return address, written
// together on a single enable. Cleared by synchronous reset.
module exc_save_slot #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] st_d,
    input  logic [XLEN-1:0] ra_d,
    output logic [XLEN-1:0] st_q,
    output logic [XLEN-1:0] ra_q
);

    // Capture both halves of the pair on the enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            ra_q <= '0;
        end else if (we) begin
            st_q <= st_d;
            ra_q <= ra_d;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception, breakpoint and interrupt entry controller.
// Each cycle at most one request is accepted; its register updates
// appear one clock later together with entry_done. Assumes pc_in and
// status_in reflect the architectural state of the entering instruction.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] RESET_VEC = 32'h0,
    parameter logic [31:0] EXC_VEC   = 32'h4,
    parameter logic [31:0] FAST_VEC  = 32'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_cause,
    input  logic              brk_valid,
    input  logic              irq_req,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   status_in,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   status_out,
    output logic [XLEN-1:0]   estatus_out,
    output logic [XLEN-1:0]   bstatus_out,
    output logic [XLEN-1:0]   cause_out,
    output logic [XLEN-1:0]   tlbmisc_out,
    output logic [XLEN-1:0]   ea_out,
    output logic [XLEN-1:0]   ba_out,
    output logic              entry_done
);

    localparam int NSLOT = 2;   // slot 0: exception/interrupt, slot 1: breakpoint

    kind_t             kind;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   status_nx, ret_addr, cause_nx, tlbmisc_nx, vec_nx;
    logic              save_exc, save_brk, take;
    logic [NSLOT-1:0]  slot_we;
    logic [XLEN-1:0]   slot_st [NSLOT];
    logic [XLEN-1:0]   slot_ra [NSLOT];

    exc_arbiter u_arb (
        .exc_valid (exc_valid),
        .exc_cause (exc_cause),
        .brk_valid (brk_valid),
        .irq_req   (irq_req),
        .pie       (status_in[ST_PIE]),
        .eh        (status_in[ST_EH]),
        .kind      (kind),
        .code      (code)
    );

    exc_update #(
        .XLEN     (XLEN),
        .EXC_VEC  (EXC_VEC),
        .FAST_VEC (FAST_VEC)
    ) u_upd (
        .kind       (kind),
        .code       (code),
        .status_in  (status_in),
        .pc_in      (pc_in),
        .cause_q    (cause_out),
        .tlbmisc_q  (tlbmisc_out),
        .status_nx  (status_nx),
        .ret_addr   (ret_addr),
        .save_exc   (save_exc),
        .save_brk   (save_brk),
        .cause_nx   (cause_nx),
        .tlbmisc_nx (tlbmisc_nx),
        .vec_nx     (vec_nx)
    );

    assign take    = (kind != K_NONE);
    assign slot_we = {save_brk, save_exc};

    // Saved-state pairs, one per entry family
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        exc_save_slot #(.XLEN(XLEN)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (slot_we[s]),
            .st_d  (status_in),
            .ra_d  (ret_addr),
            .st_q  (slot_st[s]),
            .ra_q  (slot_ra[s])
        );
    end

    assign estatus_out = slot_st[0];
    assign ea_out      = slot_ra[0];
    assign bstatus_out = slot_st[1];
    assign ba_out      = slot_ra[1];

    // Status, vector, cause and TLB control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out      <= RESET_VEC[XLEN-1:0];
            status_out  <= '0;
            cause_out   <= '0;
            tlbmisc_out <= '0;
        end else if (take) begin
            pc_out      <= vec_nx;
            status_out  <= status_nx;
            cause_out   <= cause_nx;
            tlbmisc_out <= tlbmisc_nx;
        end
    end

    // Completion strobe, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) entry_done <= 1'b0;
        else        entry_done <= take;
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for exc_entry_ctrl, attached by bind below.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] RESET_VEC = 32'h0,
    parameter logic [31:0] EXC_VEC   = 32'h4,
    parameter logic [31:0] FAST_VEC  = 32'h8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_cause,
    input logic              brk_valid,
    input logic              irq_req,
    input logic [XLEN-1:0]   status_in,
    input logic [XLEN-1:0]   pc_out,
    input logic [XLEN-1:0]   status_out,
    input logic [XLEN-1:0]   estatus_out,
    input logic [XLEN-1:0]   cause_out,
    input logic [XLEN-1:0]   tlbmisc_out,
    input logic [XLEN-1:0]   ea_out,
    input logic              entry_done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_out == RESET_VEC[XLEN-1:0] && status_out == '0 && !entry_done));

    // R11
    done_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (pc_out == EXC_VEC[XLEN-1:0] || pc_out == FAST_VEC[XLEN-1:0]));

    // R3
    done_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (!status_out[ST_PIE] && !status_out[ST_U] &&
                        (status_out[ST_EH] || status_out[ST_IH])));

    // R4
    cause_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cause_out[1:0]) && $stable(cause_out[XLEN-1:CF_HI+1]));

    // R2
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !status_in[ST_PIE] && !exc_valid && !brk_valid) |=> !entry_done);

    // R6
    double_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == C_TMISS && status_in[ST_EH]) |=>
            ($stable(ea_out) && $stable(estatus_out) && tlbmisc_out[TM_DBL] &&
             pc_out == EXC_VEC[XLEN-1:0]));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN      (XLEN),
    .RESET_VEC (RESET_VEC),
    .EXC_VEC   (EXC_VEC),
    .FAST_VEC  (FAST_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid   (exc_valid),
    .exc_cause   (exc_cause),
    .brk_valid   (brk_valid),
    .irq_req     (irq_req),
    .status_in   (status_in),
    .pc_out      (pc_out),
    .status_out  (status_out),
    .estatus_out (estatus_out),
    .cause_out   (cause_out),
    .tlbmisc_out (tlbmisc_out),
    .ea_out      (ea_out),
    .entry_done  (entry_done)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_cause = '0;
    logic        brk_valid = 1'b0;
    logic        irq_req = 1'b0;
    logic [31:0] pc_in = '0;
    logic [31:0] status_in = '0;
    logic [31:0] pc_out, status_out, estatus_out, bstatus_out;
    logic [31:0] cause_out, tlbmisc_out, ea_out, ba_out;
    logic        entry_done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // expected model state
    logic [31:0] m_pc, m_st, m_est, m_bst, m_cause, m_tm, m_ea, m_ba;
    logic        m_done;
    string       tag;

    always #2 clk = ~clk;   // 250 MHz

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .brk_valid(brk_valid), .irq_req(irq_req), .pc_in(pc_in),
        .status_in(status_in), .pc_out(pc_out), .status_out(status_out),
        .estatus_out(estatus_out), .bstatus_out(bstatus_out),
        .cause_out(cause_out), .tlbmisc_out(tlbmisc_out), .ea_out(ea_out),
        .ba_out(ba_out), .entry_done(entry_done)
    );

    task automatic chk(input string t, input string nm, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", t, nm, act, exp);
        end
    endtask

    // Model of the requirements for one clock of stimulus
    task automatic model_step();
        bit eh, take, save_e, save_b, irq_ok;
        logic [4:0] code;
        eh = status_in[2];
        irq_ok = irq_req && status_in[0];
        take = 1; save_e = 0; save_b = 0; code = 0;
        if (exc_valid && (brk_valid || irq_req)) tag = "R10";
        if (exc_valid) begin
            code = exc_cause;
            if (exc_cause == 12) begin
                if (!eh) begin
                    if (!(brk_valid || irq_req)) tag = "R5";
                    save_e = 1; m_tm[3] = 0; m_tm[18] = 1; m_pc = 32'h8;
                end else begin
                    if (!(brk_valid || irq_req)) tag = "R6";
                    m_tm[3] = 1; m_pc = 32'h4;
                end
            end else if (exc_cause >= 13 && exc_cause <= 15) begin
                if (!(brk_valid || irq_req)) tag = "R8";
                save_e = 1; if (!eh) m_tm[18] = 1; m_pc = 32'h4;
            end else begin
                if (!(brk_valid || irq_req)) tag = "R7";
                save_e = !eh; m_pc = 32'h4;
            end
        end else if (brk_valid) begin
            tag = irq_req ? "R10" : "R9";
            code = 31; save_b = !eh; m_pc = 32'h4;
        end else if (irq_ok) begin
            tag = "R3";
            code = 2; save_e = 1; m_pc = 32'h4;
        end else begin
            tag = irq_req ? "R2" : "R11";
            take = 0;
        end
        if (save_e) begin m_est = status_in; m_ea = pc_in + 4; end
        if (save_b) begin m_bst = status_in; m_ba = pc_in + 4; end
        if (take) begin
            m_st = status_in;
            m_st[0] = 0; m_st[1] = 0;
            if (!exc_valid && !brk_valid) m_st[3] = 1; else m_st[2] = 1;
            m_cause[6:2] = code;
        end
        m_done = take;
    endtask

    task automatic compare_all();
        chk(tag, "pc", pc_out, m_pc);
        chk(tag, "status", status_out, m_st);
        chk("R12", "status_hi", {status_out[31:4], 4'h0}, {m_st[31:4], 4'h0});
        chk(tag, "estatus", estatus_out, m_est);
        chk(tag, "bstatus", bstatus_out, m_bst);
        chk("R4", "cause", cause_out, m_cause);
        chk(tag, "tlbmisc", tlbmisc_out, m_tm);
        chk(tag, "ea", ea_out, m_ea);
        chk(tag, "ba", ba_out, m_ba);
        chk("R11", "entry_done", {31'b0, entry_done}, {31'b0, m_done});
    endtask

    task automatic model_reset();
        m_pc = 0; m_st = 0; m_est = 0; m_bst = 0; m_cause = 0; m_tm = 0;
        m_ea = 0; m_ba = 0; m_done = 0; tag = "R1";
    endtask

    // Called at a negedge: drive, predict, wait for edge, compare
    task automatic step(input bit ev, input logic [4:0] c, input bit br,
                        input bit iq, input logic [31:0] st, input logic [31:0] pc);
        exc_valid = ev; exc_cause = c; brk_valid = br; irq_req = iq;
        status_in = st; pc_in = pc;
        model_step();
        @(posedge clk); #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        exc_valid = 1; exc_cause = 5'd12; irq_req = 1; status_in = 32'h1;
        model_reset();
        @(posedge clk); #1;
        compare_all();
        @(negedge clk);
        rst_n = 1;
        exc_valid = 0; irq_req = 0;
    endtask

    function automatic logic [4:0] pick_cause(input int r);
        case (r % 12)
            0: return 5'd3;   1: return 5'd5;   2: return 5'd6;
            3: return 5'd9;   4: return 5'd10;  5: return 5'd12;
            6: return 5'd13;  7: return 5'd14;  8: return 5'd15;
            9: return 5'd12;  10: return 5'd8;  default: return 5'd0;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1 reset state
        do_reset();
        // R2 masked interrupt
        step(0, 0, 0, 1, 32'hA000_0002, 32'h100);
        // R3 interrupt taken
        step(0, 0, 0, 1, 32'h1234_5673, 32'h200);
        // R5 fast miss, then R6 double miss
        step(1, 5'd12, 0, 0, 32'h0000_0003, 32'h300);
        step(1, 5'd12, 0, 0, 32'h0000_0007, 32'h304);
        // R7 nested general exception keeps saved state
        step(1, 5'd3, 0, 0, 32'h0000_0001, 32'h400);
        step(1, 5'd9, 0, 0, 32'h0000_0004, 32'h404);
        // R8 permission with EH set and clear
        step(1, 5'd14, 0, 0, 32'h0000_0006, 32'h500);
        do_reset();
        step(1, 5'd15, 0, 0, 32'hF000_0003, 32'h504);
        // R9 breakpoint, outer then nested
        step(0, 0, 1, 0, 32'h0000_0003, 32'h600);
        step(0, 0, 1, 0, 32'h0000_0004, 32'h700);
        // R10 coincident requests
        step(1, 5'd5, 1, 1, 32'h0000_0001, 32'h800);
        step(0, 0, 1, 1, 32'h0000_0001, 32'h900);
        // R11 idle holds
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 32'hA00);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit ev, br, iq;
            logic [31:0] st;
            ev = ($urandom % 100) < 35;
            br = ($urandom % 100) < 12;
            iq = ($urandom % 100) < 45;
            st = $urandom;
            if (i % 500 == 499) do_reset();
            else step(ev, pick_cause($urandom), br, iq, st, {$urandom, 2'b00} >> 0);
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule